// File: doc/BRIEF.md
# Keyed Access Unlock Sequence Detector

This block guards a protected information region of an embedded flash. It watches every write to a single access-control register. The region opens only after three fixed 32-bit key words have been written to that register, one after another and in a fixed order. Any write of a value that is not a key shuts the region again. The same applies to a key that arrives out of order. The flash array and the logic that enforces the gate are outside this block.

The block also takes the address of the access being attempted. It decides whether that address falls inside the protected window. This combinational range result is combined with the registered unlock state to give a grant that downstream logic uses to pass or block the access. A read of the access-control register returns only the lock status bit, so the key values can never be recovered through the register.

Top module: `info_key_guard`

## Requirements
- R1: After reset the detector is at its start step and `unlocked` is 0.
- R2: Writing 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 as three consecutive register writes sets `unlocked` to 1 in the cycle after the clock edge that accepts the third write.
- R3: A write of any value that is not one of the three keys returns the detector to its start step and clears `unlocked` from the next cycle on, both during a sequence and when unlocked (for example 0x00001234 or 0xDEADBEEF).
- R4: A key word that does not match the expected step returns the detector to its start step unless it is the first key. Examples are the second key written first, or a key repeated out of place.
- R5: A write of the first key at any step before the unlocked state counts as step one of a new sequence.
- R6: Cycles without a register write leave the sequence progress and `unlocked` unchanged.
- R7: While unlocked, a write of any of the three key words keeps `unlocked` at 1.
- R8: `ctlRdData` is 0 in bits 31..1, and bit 0 equals `unlocked`.
- R9: `accessOk` is 1 exactly when `unlocked` is 1 and `regionAddr` lies in [INFO_BASE, INFO_BASE + 2*INFO_SIZE). This is combinational in the address. With the defaults the window is 0x04000 to 0x07FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Write strobe for the access-control register |
| ctlWrData | input | 32 | Data written to the access-control register |
| regionAddr | input | 20 | Address of the access being checked |
| ctlRdData | output | 32 | Read value of the access-control register (lock status only) |
| unlocked | output | 1 | Protected region is open |
| accessOk | output | 1 | Open and address inside the protected window |

## Verification
Two functions can fall on the same write: aborting a partial sequence and starting a new one. This happens when the first key is written in place of the second or third key. The vector table provokes this with runs such as key1, key2, key1, key2, key3 and key1, key1, key2, key3. It then judges `unlocked` and the read value after each write against the sequence rules. A second overlap is a range check against a write that changes the lock state. The bench holds an in-window address across the third key and across a locking write, and checks that `accessOk` follows `unlocked` in that same cycle.

// File: rtl/info_key_guard_pkg.sv
package info_key_guard_pkg;
  localparam int KEY_COUNT = 3;
  localparam int KEY_W = 32;
  localparam int STEP_W = $clog2(KEY_COUNT + 1);

  localparam logic [KEY_W-1:0] KEY_WORDS [KEY_COUNT] = '{
    32'h3A7F_5CA3,
    32'hA1E3_4F20,
    32'h9608_B2C1
  };

  typedef struct packed {
    logic [KEY_COUNT-1:0] hit;
    logic                 anyKey;
  } keyMatch_t;
endpackage

// File: rtl/info_key_datapath.sv
module info_key_datapath
  import info_key_guard_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] INFO_BASE = 20'h0_4000,
  parameter logic [ADDR_W-1:0] INFO_SIZE = 20'h0_2000
) (
  input  logic [KEY_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isOpen,
  output keyMatch_t         match,
  output logic [KEY_W-1:0]  rdData,
  output logic              grant
);
  localparam logic [ADDR_W:0] WIN_LO = {1'b0, INFO_BASE};
  localparam logic [ADDR_W:0] WIN_HI = {1'b0, INFO_BASE} + {INFO_SIZE, 1'b0};

  logic [KEY_COUNT-1:0] hitVec;
  logic                 inWindow;

  for (genvar k = 0; k < KEY_COUNT; k++) begin : g_cmp
    assign hitVec[k] = (wrData == KEY_WORDS[k]);
  end

  always_comb begin
    match.hit    = hitVec;
    match.anyKey = |hitVec;
  end

  assign inWindow = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
  assign grant    = isOpen && inWindow;
  assign rdData   = {{(KEY_W-1){1'b0}}, isOpen};
endmodule

// File: rtl/info_key_control.sv
module info_key_control
  import info_key_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  keyMatch_t match,
  output logic      isOpen
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(KEY_COUNT);
  localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

  logic [STEP_W-1:0] step, nextStep;

  always_comb begin
    nextStep = step;
    if (wrEn) begin
      if (step == LAST) begin
        nextStep = match.anyKey ? LAST : '0;
      end else if (match.hit[step]) begin
        nextStep = step + ONE;
      end else if (match.hit[0]) begin
        nextStep = ONE;
      end else begin
        nextStep = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) step <= '0;
    else       step <= nextStep;
  end

  assign isOpen = (step == LAST);
endmodule

// File: rtl/info_key_guard.sv
module info_key_guard
  import info_key_guard_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] INFO_BASE = 20'h0_4000,
  parameter logic [ADDR_W-1:0] INFO_SIZE = 20'h0_2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [31:0]       ctlWrData,
  input  logic [ADDR_W-1:0] regionAddr,
  output logic [31:0]       ctlRdData,
  output logic              unlocked,
  output logic              accessOk
);
  keyMatch_t matchBus;
  logic      openState;

  info_key_datapath #(
    .ADDR_W(ADDR_W), .INFO_BASE(INFO_BASE), .INFO_SIZE(INFO_SIZE)
  ) u_dp (
    .wrData(ctlWrData), .addr(regionAddr), .isOpen(openState),
    .match(matchBus), .rdData(ctlRdData), .grant(accessOk)
  );

  info_key_control u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(ctlWrEn), .match(matchBus), .isOpen(openState)
  );

  assign unlocked = openState;
endmodule

// File: rtl/info_key_guard_chk.sv
module info_key_guard_chk #(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] INFO_BASE = 20'h0_4000
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlWrEn,
  input logic [31:0]       ctlWrData,
  input logic [ADDR_W-1:0] regionAddr,
  input logic [31:0]       ctlRdData,
  input logic              unlocked,
  input logic              accessOk
);
  AST_OPEN_ON_LAST_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> ($past(ctlWrEn) && $past(ctlWrData) == 32'h9608_B2C1)); // R2

  AST_NONKEY_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData != 32'h3A7F_5CA3 && ctlWrData != 32'hA1E3_4F20
     && ctlWrData != 32'h9608_B2C1) |=> !unlocked); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrEn |=> $stable(unlocked)); // R6

  AST_KEY_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && ctlWrEn && (ctlWrData == 32'h3A7F_5CA3 || ctlWrData == 32'hA1E3_4F20
     || ctlWrData == 32'h9608_B2C1)) |=> unlocked); // R7

  AST_READ_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[31:1] == '0 && ctlRdData[0] == unlocked); // R8

  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    accessOk |-> (unlocked && regionAddr >= INFO_BASE)); // R9
endmodule

bind info_key_guard info_key_guard_chk #(.ADDR_W(ADDR_W), .INFO_BASE(INFO_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
  .regionAddr(regionAddr), .ctlRdData(ctlRdData), .unlocked(unlocked), .accessOk(accessOk)
);

// File: tb/sim_info_key_guard.sv
module sim_info_key_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K0 = 32'h3A7F_5CA3;
  localparam logic [31:0] K1 = 32'hA1E3_4F20;
  localparam logic [31:0] K2 = 32'h9608_B2C1;
  localparam int NVEC = 22;
  // {write data, expected unlocked after the write}
  localparam logic [32:0] VEC [NVEC] = '{
    {32'h0000_1234, 1'b0},            // R3
    {K0, 1'b0}, {K1, 1'b0}, {K2, 1'b1},  // R2
    {32'hDEAD_BEEF, 1'b0},            // R3 relock
    {K1, 1'b0}, {K2, 1'b0},           // R4 out of order
    {K0, 1'b0}, {K0, 1'b0}, {K1, 1'b0}, {K2, 1'b1},  // R5 repeat first key
    {K0, 1'b1}, {K1, 1'b1},           // R7
    {32'h0000_0000, 1'b0},            // R3
    {K0, 1'b0}, {K1, 1'b0}, {K0, 1'b0}, {K1, 1'b0}, {K2, 1'b1},  // R5 mid restart
    {32'h9608_B2C0, 1'b0},            // R3 near miss
    {K0, 1'b0}, {K2, 1'b0}            // R4 skipped step
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic        ctlWrEn = 0;
  logic [31:0] ctlWrData = '0;
  logic [19:0] regionAddr = 20'h0_5000;
  logic [31:0] ctlRdData;
  logic        unlocked, accessOk;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  info_key_guard u0 (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .regionAddr(regionAddr), .ctlRdData(ctlRdData), .unlocked(unlocked), .accessOk(accessOk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); ctlWrEn = 1; ctlWrData = d;
    @(negedge clk); ctlWrEn = 0; ctlWrData = '0;
  endtask

  task automatic unlockAll();
    wr(K0); wr(K1); wr(K2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {31'b0, unlocked}, 32'd0);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", {31'b0, unlocked}, 32'd0);
    check("R8 reset read", ctlRdData, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][32:1]);
      check($sformatf("R2-table step %0d unlocked", i), {31'b0, unlocked}, {31'b0, VEC[i][0]});
      check($sformatf("R8 table step %0d read", i), ctlRdData, {31'b0, VEC[i][0]});
    end

    // R6: idle cycles between keys do not disturb progress
    wr(32'h1); wr(K0);
    repeat (5) @(negedge clk);
    wr(K1);
    repeat (3) @(negedge clk);
    wr(K2);
    check("R6 idle gaps", {31'b0, unlocked}, 32'd1);
    repeat (4) @(negedge clk);
    check("R6 idle holds open", {31'b0, unlocked}, 32'd1);

    // R9: window boundaries while open
    regionAddr = 20'h0_3FFF; #1; check("R9 below base", {31'b0, accessOk}, 32'd0);
    regionAddr = 20'h0_4000; #1; check("R9 at base", {31'b0, accessOk}, 32'd1);
    regionAddr = 20'h0_7FFF; #1; check("R9 last", {31'b0, accessOk}, 32'd1);
    regionAddr = 20'h0_8000; #1; check("R9 past end", {31'b0, accessOk}, 32'd0);

    // R9 with lock change in same cycle as in-window address
    regionAddr = 20'h0_4800;
    wr(32'hDEAD_BEEF);
    check("R3 relock", {31'b0, unlocked}, 32'd0);
    check("R9 locked in window", {31'b0, accessOk}, 32'd0);
    unlockAll();
    check("R9 grant after key", {31'b0, accessOk}, 32'd1);

    // R1: reset while open
    @(negedge clk); rstN = 0;
    @(negedge clk);
    check("R1 reset clears", {31'b0, unlocked}, 32'd0);
    rstN = 1;
    @(negedge clk);
    wr(K1); wr(K2);
    check("R4 partial after reset", {31'b0, unlocked}, 32'd0);
    wr(K1); wr(K0); wr(K1); wr(K2);
    check("R5 after wrong key", {31'b0, unlocked}, 32'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule